// File: doc/BRIEF.md
# Majority-Capable Memory Subarray Model

This block is a cycle-level, synthesizable model of one memory subarray that computes in place. Storage is organised as rows of `LANES` bits, and every column is an independent SIMD lane. A small set of ordinary data rows holds operands. A few reserved compute rows are the only rows that can be opened three at a time. Two constant rows, one all zeros and one all ones, can be read but never written.

A command port accepts row activations and precharges. The row buffer acts on the order of activations. The first activation after a close latches the row into the buffer. Each further activation before the next precharge copies the buffer into the newly opened row. Activating one of the predefined compute-row triples from the closed state places the per-lane majority of the three rows into the buffer and writes that result back into all three rows.

With a constant row copied into a compute row, the majority gives AND (zeros) or OR (ones). Multi-bit operands are kept in a vertical layout: bit i of every lane sits in the row at base address plus i, LSB row first. A host port reads any row combinationally and loads rows while the subarray is closed.

Top module: `simd_subarray`

## Requirements
- R1: The sequence ACT of source row, ACT of destination row, PRE leaves the destination equal to the source, and the source is unchanged.
- R2: An ACT of a triple address while no row is open puts the per-lane majority of the group's three compute rows on `row_buf` after that edge, and all three rows hold the same value after it.
- R3: Address 0x3E8 always reads all zeros and 0x3E9 always reads all ones. Host writes and copies into them have no effect. Copying 0x3E8 into a group member and then activating the group yields A AND B; copying 0x3E9 yields A OR B.
- R4: Data row r is at address r (0..31). Compute row k is at 0x3E0+k (0..5). Triple address 0x3F0+g selects compute rows 3g, 3g+1 and 3g+2, and leaves the other group's rows and the data rows untouched.
- R5: The host port returns the addressed row combinationally on `host_rdata`. A host write with no row open and no command presented stores `host_wdata` in a data or compute row at the next edge.
- R6: `rows_open` counts the rows opened since the last precharge. It reads 1 and 2 after first and second single activations, and 3 after a triple or a third activation. A PRE returns it to 0.
- R7: An ACT while `rows_open` is 3, or to an unmapped address (for example 0x100 or 0x3F2), pulses `err` for one cycle. It is otherwise ignored: `row_buf`, `rows_open` and every row keep their values.
- R8: A host write while any row is open, or in the same cycle as a command, is blocked and pulses `err`; the addressed row keeps its value.
- R9: Activations after the first copy the buffer into every further row opened. A single row receives it. A triple address opened as the second activation receives it in all three rows and sets `rows_open` to 3.
- R10: After reset every row reads zero, and `row_buf`, `rows_open` and `err` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 1 | 0 = activate, 1 = precharge |
| cmd_addr | input | 10 | Row or triple address of an activation |
| host_we | input | 1 | Host row write strobe |
| host_addr | input | 10 | Host read/write row address |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Contents of the row at `host_addr` |
| row_buf | output | 64 | Row buffer contents |
| rows_open | output | 2 | Number of rows open, saturating at 3 |
| err | output | 1 | One-cycle pulse for an ignored command or blocked write |

## Verification
The bench builds the block with its default parameters: 64 lanes, 32 data rows, six compute rows and two triple groups. Both groups are driven in alternation, so each vector also checks that the idle group is left alone. The first unused triple address, 0x3F2, is then a real unmapped case. Full-width patterns put the outermost lanes, bit 0 and bit 63, under the majority check. With four or more rows reachable per open cycle, the limit of three open rows can also be hit.

// File: rtl/simd_sub_pkg.sv
package simd_sub_pkg;
   typedef enum logic [2:0] {
      RK_NONE  = 3'd0,
      RK_DATA  = 3'd1,
      RK_COMP  = 3'd2,
      RK_ZERO  = 3'd3,
      RK_ONES  = 3'd4,
      RK_GROUP = 3'd5
   } row_kind_e;

   typedef enum logic {
      OP_ACT = 1'b0,
      OP_PRE = 1'b1
   } cmd_op_e;
endpackage

// File: rtl/sub_row_decode.sv
module sub_row_decode
   import simd_sub_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter int DATA_ROWS = 32,
   parameter int COMP_ROWS = 6,
   parameter int GROUPS    = 2,
   parameter int IDX_W     = 6,
   parameter logic [ADDR_W-1:0] COMP_BASE  = 'h3E0,
   parameter logic [ADDR_W-1:0] ZERO_ADDR  = 'h3E8,
   parameter logic [ADDR_W-1:0] ONES_ADDR  = 'h3E9,
   parameter logic [ADDR_W-1:0] GROUP_BASE = 'h3F0
) (
   input  logic [ADDR_W-1:0] addr,
   output row_kind_e         kind,
   output logic [IDX_W-1:0]  idx
);
   localparam logic [ADDR_W-1:0] DATA_END  = ADDR_W'(DATA_ROWS);
   localparam logic [ADDR_W-1:0] COMP_CNT  = ADDR_W'(COMP_ROWS);
   localparam logic [ADDR_W-1:0] GROUP_CNT = ADDR_W'(GROUPS);
   localparam logic [IDX_W-1:0]  COMP_IDX0 = IDX_W'(DATA_ROWS);

   logic [ADDR_W-1:0] off_c;
   logic [ADDR_W-1:0] off_g;

   always_comb begin
      off_c = addr - COMP_BASE;
      off_g = addr - GROUP_BASE;
      kind  = RK_NONE;
      idx   = '0;
      if (addr < DATA_END) begin
         kind = RK_DATA;
         idx  = IDX_W'(addr);
      end else if (addr == ZERO_ADDR) begin
         kind = RK_ZERO;
      end else if (addr == ONES_ADDR) begin
         kind = RK_ONES;
      end else if (addr >= COMP_BASE && off_c < COMP_CNT) begin
         kind = RK_COMP;
         idx  = COMP_IDX0 + IDX_W'(off_c);
      end else if (addr >= GROUP_BASE && off_g < GROUP_CNT) begin
         kind = RK_GROUP;
         idx  = COMP_IDX0 + IDX_W'(off_g * ADDR_W'(3));
      end
   end
endmodule

// File: rtl/sub_maj3.sv
module sub_maj3 #(
   parameter int LANES = 64
) (
   input  logic [LANES-1:0] a,
   input  logic [LANES-1:0] b,
   input  logic [LANES-1:0] c,
   output logic [LANES-1:0] y
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign y[l] = (a[l] & b[l]) | (c[l] & (a[l] | b[l]));
   end
endmodule

// File: rtl/sub_row_store.sv
module sub_row_store #(
   parameter int LANES = 64,
   parameter int NR    = 38
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NR-1:0]              wr_mask,
   input  logic [LANES-1:0]           wr_data,
   output logic [NR-1:0][LANES-1:0]   rows_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rows_o <= '0;
      end else begin
         for (int r = 0; r < NR; r++) begin
            if (wr_mask[r]) rows_o[r] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/simd_subarray.sv
module simd_subarray
   import simd_sub_pkg::*;
#(
   parameter int LANES     = 64,
   parameter int DATA_ROWS = 32,
   parameter int COMP_ROWS = 6,
   parameter int GROUPS    = 2,
   parameter int ADDR_W    = 10,
   parameter logic [ADDR_W-1:0] COMP_BASE  = 'h3E0,
   parameter logic [ADDR_W-1:0] ZERO_ADDR  = 'h3E8,
   parameter logic [ADDR_W-1:0] ONES_ADDR  = 'h3E9,
   parameter logic [ADDR_W-1:0] GROUP_BASE = 'h3F0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [LANES-1:0]  host_wdata,
   output logic [LANES-1:0]  host_rdata,
   output logic [LANES-1:0]  row_buf,
   output logic [1:0]        rows_open,
   output logic              err
);
   localparam int NR    = DATA_ROWS + COMP_ROWS;
   localparam int IDX_W = $clog2(NR + 3);
   localparam logic [NR-1:0] ONE_HOT = NR'(1);
   localparam logic [NR-1:0] TRIPLE  = NR'(7);

   if (COMP_ROWS < 3 * GROUPS) begin : g_chk_groups
      $error("simd_subarray: COMP_ROWS must cover 3*GROUPS rows");
   end
   if (DATA_ROWS > int'(COMP_BASE)) begin : g_chk_map
      $error("simd_subarray: data rows overlap compute addresses");
   end
   if (LANES < 1) begin : g_chk_lanes
      $error("simd_subarray: LANES must be positive");
   end

   row_kind_e        ckind, hkind;
   logic [IDX_W-1:0] cidx, hidx;
   logic [NR-1:0][LANES-1:0] rows;
   logic [NR-1:0]    wr_mask;
   logic [LANES-1:0] wr_data;
   logic [LANES-1:0] crow, maj_out;
   logic [LANES-1:0] rbuf, nxt_rbuf;
   logic [1:0]       cnt, nxt_cnt;
   logic             nxt_err, err_q;
   logic             is_act, is_pre;

   sub_row_decode #(
      .ADDR_W(ADDR_W), .DATA_ROWS(DATA_ROWS), .COMP_ROWS(COMP_ROWS),
      .GROUPS(GROUPS), .IDX_W(IDX_W), .COMP_BASE(COMP_BASE),
      .ZERO_ADDR(ZERO_ADDR), .ONES_ADDR(ONES_ADDR), .GROUP_BASE(GROUP_BASE)
   ) u_cmd_dec (.addr(cmd_addr), .kind(ckind), .idx(cidx));

   sub_row_decode #(
      .ADDR_W(ADDR_W), .DATA_ROWS(DATA_ROWS), .COMP_ROWS(COMP_ROWS),
      .GROUPS(GROUPS), .IDX_W(IDX_W), .COMP_BASE(COMP_BASE),
      .ZERO_ADDR(ZERO_ADDR), .ONES_ADDR(ONES_ADDR), .GROUP_BASE(GROUP_BASE)
   ) u_host_dec (.addr(host_addr), .kind(hkind), .idx(hidx));

   sub_row_store #(.LANES(LANES), .NR(NR)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_mask(wr_mask), .wr_data(wr_data),
      .rows_o(rows)
   );

   sub_maj3 #(.LANES(LANES)) u_maj (
      .a(rows[cidx]),
      .b(rows[cidx + IDX_W'(1)]),
      .c(rows[cidx + IDX_W'(2)]),
      .y(maj_out)
   );

   always_comb begin
      case (ckind)
         RK_DATA, RK_COMP: crow = rows[cidx];
         RK_ONES:          crow = '1;
         default:          crow = '0;
      endcase
      case (hkind)
         RK_DATA, RK_COMP: host_rdata = rows[hidx];
         RK_ONES:          host_rdata = '1;
         default:          host_rdata = '0;
      endcase
   end

   assign is_act = cmd_valid && (cmd_op_e'(cmd_op) == OP_ACT);
   assign is_pre = cmd_valid && (cmd_op_e'(cmd_op) == OP_PRE);

   always_comb begin
      wr_mask  = '0;
      wr_data  = rbuf;
      nxt_rbuf = rbuf;
      nxt_cnt  = cnt;
      nxt_err  = 1'b0;
      if (is_pre) begin
         nxt_cnt = 2'd0;
      end else if (is_act) begin
         if (ckind == RK_NONE || cnt == 2'd3) begin
            nxt_err = 1'b1;
         end else if (cnt == 2'd0) begin
            if (ckind == RK_GROUP) begin
               nxt_rbuf = maj_out;
               wr_data  = maj_out;
               wr_mask  = TRIPLE << cidx;
               nxt_cnt  = 2'd3;
            end else begin
               nxt_rbuf = crow;
               nxt_cnt  = 2'd1;
            end
         end else begin
            if (ckind == RK_GROUP) begin
               wr_mask = TRIPLE << cidx;
               nxt_cnt = 2'd3;
            end else begin
               if (ckind inside {RK_DATA, RK_COMP}) wr_mask = ONE_HOT << cidx;
               nxt_cnt = cnt + 2'd1;
            end
         end
      end
      if (host_we) begin
         if (cnt != 2'd0 || cmd_valid) begin
            nxt_err = 1'b1;
         end else if (hkind inside {RK_DATA, RK_COMP}) begin
            wr_mask = ONE_HOT << hidx;
            wr_data = host_wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbuf  <= '0;
         cnt   <= 2'd0;
         err_q <= 1'b0;
      end else begin
         rbuf  <= nxt_rbuf;
         cnt   <= nxt_cnt;
         err_q <= nxt_err;
      end
   end

   assign row_buf   = rbuf;
   assign rows_open = cnt;
   assign err       = err_q;

   AST_COPY_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (is_act && !host_we && (cnt == 2'd1 || cnt == 2'd2) && (ckind == RK_DATA || ckind == RK_COMP))
      |=> rows[$past(cidx)] == $past(rbuf)); // R1

   AST_TRA_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (is_act && cnt == 2'd0 && ckind == RK_GROUP)
      |=> (rows[$past(cidx)] == row_buf) && (rows[$past(cidx + IDX_W'(1))] == row_buf)
          && (rows[$past(cidx + IDX_W'(2))] == row_buf)); // R2

   AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |=> rows_open == 2'd0); // R6

   AST_FULL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (is_act && cnt == 2'd3 && !host_we)
      |=> err && $stable(row_buf) && $stable(rows) && rows_open == 2'd3); // R7

   AST_HOST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && cnt != 2'd0 && !cmd_valid)
      |=> err && $stable(rows)); // R8
endmodule

// File: tb/tb_simd_subarray.sv
module tb_simd_subarray;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_op = 1'b0;
   logic [9:0]  cmd_addr = '0;
   logic        host_we = 1'b0;
   logic [9:0]  host_addr = '0;
   logic [63:0] host_wdata = '0;
   logic [63:0] host_rdata, row_buf;
   logic [1:0]  rows_open;
   logic        err;

   int nchk = 0;
   int nfail = 0;

   always #2 clk = ~clk;

   simd_subarray dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .row_buf(row_buf),
      .rows_open(rows_open), .err(err)
   );

   localparam logic [191:0] VEC [0:5] = '{
      {64'hFFFF0000FFFF0000, 64'hFF00FF00FF00FF00, 64'hF0F0F0F0F0F0F0F0},
      {64'h0000000000000000, 64'hFFFFFFFFFFFFFFFF, 64'h0123456789ABCDEF},
      {64'hAAAAAAAAAAAAAAAA, 64'h5555555555555555, 64'hFFFFFFFFFFFFFFFF},
      {64'hDEADBEEFCAFEF00D, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210},
      {64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF},
      {64'h8000000000000001, 64'h8000000000000000, 64'h0000000000000001}
   };

   function automatic logic [63:0] maj_ref(input logic [63:0] a, b, c);
      logic [63:0] r;
      for (int k = 0; k < 64; k++) begin
         int votes;
         votes = int'(a[k]) + int'(b[k]) + int'(c[k]);
         r[k] = (votes >= 2);
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic act(input logic [9:0] a);
      @(negedge clk); cmd_valid = 1'b1; cmd_op = 1'b0; cmd_addr = a;
      @(negedge clk); cmd_valid = 1'b0;
   endtask

   task automatic pre();
      @(negedge clk); cmd_valid = 1'b1; cmd_op = 1'b1; cmd_addr = '0;
      @(negedge clk); cmd_valid = 1'b0;
   endtask

   task automatic wr(input logic [9:0] a, input logic [63:0] d);
      @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk); host_we = 1'b0;
   endtask

   task automatic rd(input logic [9:0] a, output logic [63:0] d);
      host_addr = a; #1; d = host_rdata;
   endtask

   initial begin
      #(4 * 150000);
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      logic [63:0] d, x, y, ea, eb;
      repeat (3) @(negedge clk);
      rd(10'd5, d);
      chk("R10 row zero", d, 64'd0);
      chk("R10 row_buf", row_buf, 64'd0);
      chk("R10 rows_open", 64'(rows_open), 64'd0);
      chk("R10 err", 64'(err), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 / R4: table walk over both triple groups
      for (int i = 0; i < 6; i++) begin
         int g;
         logic [63:0] a, b, c, e, m;
         g = i % 2;
         {a, b, c} = VEC[i];
         e = maj_ref(a, b, c);
         wr(10'h3E0 + 10'(3 * g), a);
         wr(10'h3E1 + 10'(3 * g), b);
         wr(10'h3E2 + 10'(3 * g), c);
         wr(10'h3E0 + 10'(3 * (1 - g)), 64'h5A5A_0F0F_1234_8765);
         act(10'h3F0 + 10'(g));
         chk("R2 row_buf majority", row_buf, e);
         chk("R6 triple open", 64'(rows_open), 64'd3);
         pre();
         for (int k = 0; k < 3; k++) begin
            rd(10'h3E0 + 10'(3 * g + k), m);
            chk("R2 writeback", m, e);
         end
         rd(10'h3E0 + 10'(3 * (1 - g)), m);
         chk("R4 other group untouched", m, 64'h5A5A_0F0F_1234_8765);
      end

      // R5 / R1 / R6: host load and copy
      x = 64'hC0FF_EE00_1122_3344;
      y = 64'h0BAD_F00D_5566_7788;
      wr(10'd3, x);
      wr(10'd7, y);
      rd(10'd7, d);
      chk("R5 host write/read", d, y);
      act(10'd3);
      chk("R6 one open", 64'(rows_open), 64'd1);
      chk("R1 buffer latches source", row_buf, x);
      act(10'd7);
      chk("R6 two open", 64'(rows_open), 64'd2);
      pre();
      chk("R6 closed", 64'(rows_open), 64'd0);
      rd(10'd7, d);
      chk("R1 destination", d, x);
      rd(10'd3, d);
      chk("R1 source kept", d, x);

      // R9: chained copies, and a group as second activation
      wr(10'd8, 64'd0);
      wr(10'd9, 64'd1);
      wr(10'd10, 64'h1010);
      act(10'd3); act(10'd8); act(10'd9);
      chk("R6 three open", 64'(rows_open), 64'd3);
      rd(10'd8, d); chk("R9 first copy", d, x);
      rd(10'd9, d); chk("R9 second copy", d, x);
      // R7: fourth activation ignored
      act(10'd10);
      chk("R7 err full", 64'(err), 64'd1);
      chk("R7 rows_open kept", 64'(rows_open), 64'd3);
      chk("R7 row_buf kept", row_buf, x);
      rd(10'd10, d); chk("R7 row untouched", d, 64'h1010);
      @(negedge clk);
      chk("R7 err one cycle", 64'(err), 64'd0);
      pre();
      act(10'd7); act(10'h3F1);
      chk("R9 group open count", 64'(rows_open), 64'd3);
      pre();
      for (int k = 3; k < 6; k++) begin
         rd(10'h3E0 + 10'(k), d);
         chk("R9 group filled", d, x);
      end

      // R7: unmapped activations
      act(10'h3F2);
      chk("R7 err unmapped group", 64'(err), 64'd1);
      chk("R7 unmapped stays closed", 64'(rows_open), 64'd0);
      act(10'h100);
      chk("R7 err unmapped row", 64'(err), 64'd1);

      // R8: host write blocked
      act(10'd3);
      wr(10'd4, 64'hFFFF);
      chk("R8 err while open", 64'(err), 64'd1);
      pre();
      rd(10'd4, d); chk("R8 row kept", d, 64'd0);
      @(negedge clk);
      host_we = 1'b1; host_addr = 10'd4; host_wdata = 64'hABCD;
      cmd_valid = 1'b1; cmd_op = 1'b1;
      @(negedge clk);
      host_we = 1'b0; cmd_valid = 1'b0;
      chk("R8 err with command", 64'(err), 64'd1);
      rd(10'd4, d); chk("R8 row kept with command", d, 64'd0);
      wr(10'd4, 64'hABCD);
      chk("R8 no err when closed", 64'(err), 64'd0);

      // R3: constants, AND and OR
      rd(10'h3E8, d); chk("R3 zero row", d, 64'd0);
      rd(10'h3E9, d); chk("R3 ones row", d, '1);
      wr(10'h3E9, 64'd0);
      rd(10'h3E9, d); chk("R3 ones row not writable", d, '1);
      act(10'd3); act(10'h3E8); pre();
      rd(10'h3E8, d); chk("R3 zero row not copy target", d, 64'd0);
      ea = 64'hF0F0_3C3C_8001_FFFF;
      eb = 64'hFF00_0FF0_0001_1234;
      wr(10'h3E0, ea); wr(10'h3E1, eb);
      act(10'h3E8); act(10'h3E2); pre();
      act(10'h3F0); pre();
      chk("R3 AND", row_buf, ea & eb);
      wr(10'h3E0, ea); wr(10'h3E1, eb);
      act(10'h3E9); act(10'h3E2); pre();
      act(10'h3F0); pre();
      chk("R3 OR", row_buf, ea | eb);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule